// File: doc/BRIEF.md
# Burst Reader for a First-Word-Fall-Through FIFO

This block pulls a fixed-length burst of words out of an external first-word-fall-through FIFO and keeps them in a bank of registers. A host sees the block through a small memory-mapped register window. Through that window it starts a burst, watches for the burst to finish, and then reads back the words that were captured. The FIFO's output word is valid whenever its empty flag is low. A word is consumed on any clock edge where the block's read enable is high.

Two modes are offered. In waiting mode the read enable follows the FIFO's data-present state, and the slot pointer only moves when a word is taken. An empty FIFO therefore stretches the burst one element at a time, and no stale word is ever stored. In fixed-length mode the burst always lasts exactly N cycles. The block reads on each of those cycles where data is present, and it records in a per-slot mask which slots really received a word.

Top module: `burst_fifo_reader`

## Requirements
- R1: After synchronous reset, the read enable is low, the control register reads 0, the valid mask reads 0 and every data slot reads 0.
- R2: A control write with bit 0 set while idle starts a burst. From the next cycle busy (bit 1) reads 1, done (bit 2) reads 0 and the valid mask reads 0. Bit 3 of that write is latched as the mode: 0 selects waiting mode and 1 selects fixed-length mode.
- R3: While busy, the read enable is high only in cycles where the FIFO is not empty. With data always present, it stays high for exactly N consecutive cycles, and word k goes into slot k.
- R4: In waiting mode, a cycle where the FIFO is empty takes no word and does not advance the slot pointer. The burst ends only after N words have been taken, in slot order.
- R5: On the edge that stores the final word, busy drops and done rises. The read enable stays low from then until the next start.
- R6: In fixed-length mode, busy lasts exactly N cycles whatever the empty flag does. Cycle k of the burst targets slot k, and valid-mask bit k is 1 exactly when a word was taken in that cycle.
- R7: A slot that receives no word during a burst keeps its previous contents.
- R8: A start written while busy is ignored. The running burst keeps its mode and its progress.
- R9: The register map is: control at byte offset 0, valid mask at offset 4, and slot i at offset 8+4*i, zero-extended to 32 bits.
- R10: A read of any offset that is not mapped (including offsets that are not word-aligned) returns 0.
- R11: Done stays set after completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcEmpty | input | 1 | FIFO empty flag |
| srcData | input | DATA_W | FIFO output word, valid while not empty |
| srcRdEn | output | 1 | FIFO read enable; a word is consumed on each edge where it is high |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, combinational from hostAddr |

## Verification
A slot pointer that is wrong shows up at the host as words landing in the wrong slots, or as valid-mask bits that do not match the cycles where the FIFO had data. These are visible as soon as the burst ends. A sequencer that miscounts shows up earlier: the read enable stays high into the done state, or busy lasts a different number of cycles than the empty pattern predicts. Both are visible on the read-enable pin within the same cycle. If the read enable is gated wrongly, it rises while the FIFO reports empty, which the bench catches on the cycle it happens.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BUS_W = 32;

  // strobes from the sequencer to the slot bank
  typedef struct packed {
    logic clear;    // burst accepted: wipe the valid mask
    logic capture;  // store the current FIFO word into the current slot
  } seqStrobe_t;

  localparam int CTRL_START = 0;
  localparam int CTRL_BUSY  = 1;
  localparam int CTRL_DONE  = 2;
  localparam int CTRL_MODE  = 3;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             modeIn,
  input  logic             srcEmpty,
  output logic             rdEn,
  output logic             busy,
  output logic             done,
  output logic             mode,
  output logic [IDX_W-1:0] slotIdx,
  output seqStrobe_t       strb
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             busyQ, doneQ, modeQ;
  logic [IDX_W-1:0] idxQ;
  logic             accept, step;

  assign accept = startReq && !busyQ;
  // fixed-length mode moves every cycle; waiting mode only when a word is taken
  assign step   = busyQ && (modeQ || !srcEmpty);
  assign rdEn   = busyQ && !srcEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      modeQ <= 1'b0;
      idxQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      doneQ <= 1'b0;
      modeQ <= modeIn;
      idxQ  <= '0;
    end else if (step) begin
      if (idxQ == LAST) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
        idxQ  <= '0;
      end else begin
        idxQ <= idxQ + IDX_W'(1);
      end
    end
  end

  assign busy         = busyQ;
  assign done         = doneQ;
  assign mode         = modeQ;
  assign slotIdx      = idxQ;
  assign strb.clear   = accept;
  assign strb.capture = rdEn;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !modeQ && srcEmpty) |=> (busyQ && idxQ == $past(idxQ)));  // R4
  AST_FIXED_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (busyQ && modeQ && idxQ != LAST) |=> (busyQ && idxQ == $past(idxQ) + IDX_W'(1)));  // R6
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busyQ |=> (!busyQ || $stable(modeQ)));  // R8
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busyQ) |-> (doneQ && !rdEn));  // R5
endmodule

// File: rtl/burst_bank.sv
module burst_bank
  import burst_pkg::*;
#(
  parameter int N      = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [DATA_W-1:0] srcData,
  input  logic [3:0]        ctrlView,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [BUS_W-1:0]  hostRdData
);
  logic [DATA_W-1:0] slotQ [N];
  logic [N-1:0]      maskQ;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slotQ[i] <= '0;
      else if (strb.capture && slotIdx == IDX_W'(i))
        slotQ[i] <= srcData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear)
      maskQ <= '0;
    else if (strb.capture)
      maskQ[slotIdx] <= 1'b1;
  end

  // host read decode
  logic [ADDR_W-1:0] wordOff;
  logic [ADDR_W-1:0] wordNum;
  logic [IDX_W-1:0]  sel;
  assign wordOff = hostAddr - ADDR_W'(8);
  assign wordNum = wordOff >> 2;
  assign sel     = IDX_W'(wordNum);

  always_comb begin
    hostRdData = '0;
    if (hostAddr == ADDR_W'(0))
      hostRdData = BUS_W'(ctrlView);
    else if (hostAddr == ADDR_W'(4))
      hostRdData = BUS_W'(maskQ);
    else if (hostAddr >= ADDR_W'(8) && hostAddr[1:0] == 2'b00 && wordNum < ADDR_W'(N))
      hostRdData = BUS_W'(slotQ[sel]);
  end

  AST_MASK_MARK: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> maskQ[$past(slotIdx)]);  // R6
  AST_MASK_WIPE: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (maskQ == '0));  // R2
endmodule

// File: rtl/burst_fifo_reader.sv
module burst_fifo_reader
  import burst_pkg::*;
#(
  parameter int N      = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srcEmpty,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcRdEn,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  seqStrobe_t       strb;
  logic [IDX_W-1:0] slotIdx;
  logic             busy, done, mode, startReq;
  logic [3:0]       ctrlView;

  assign startReq = hostWrEn && hostAddr == ADDR_W'(0) && hostWrData[CTRL_START];
  assign ctrlView = {mode, done, busy, 1'b0};

  burst_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .startReq(startReq), .modeIn(hostWrData[CTRL_MODE]),
    .srcEmpty(srcEmpty), .rdEn(srcRdEn), .busy(busy), .done(done), .mode(mode),
    .slotIdx(slotIdx), .strb(strb)
  );

  burst_bank #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .strb(strb), .slotIdx(slotIdx), .srcData(srcData),
    .ctrlView(ctrlView), .hostAddr(hostAddr), .hostRdData(hostRdData)
  );

  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    srcEmpty |-> !srcRdEn);  // R3
endmodule

// File: tb/test_burst_fifo_reader.sv
module test_burst_fifo_reader;
  localparam int N = 10;
  localparam int ENTRIES = 6;
  // entry = {mode, injectStart, emptyPattern[15:0]}; pattern bit c = empty in burst cycle c
  localparam logic [17:0] VEC [ENTRIES] = '{
    {1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 16'h002D},
    {1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b0, 16'h0249},
    {1'b0, 1'b1, 16'h0007},
    {1'b1, 1'b0, 16'hFFFF}
  };

  logic        clk = 0, rst = 1;
  logic        srcEmpty = 1, srcRdEn, hostWrEn = 0;
  logic [31:0] srcData = 0, hostWrData = 0, hostRdData;
  logic [7:0]  hostAddr = 0;
  int checks = 0, errors = 0;
  logic [31:0] expData [N];
  logic [31:0] rd;

  always #5 clk = ~clk;

  burst_fifo_reader #(.N(N), .DATA_W(32), .ADDR_W(8)) i_burst_fifo_reader (
    .clk(clk), .rst(rst), .srcEmpty(srcEmpty), .srcData(srcData), .srcRdEn(srcRdEn),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    hostAddr = a;
    #1 v = hostRdData;
  endtask

  task automatic runBurst(input logic m, input logic inject, input logic [15:0] pat,
                          input logic [31:0] base);
    int expCycles, zeros, taken, rdCount, c;
    logic [31:0] expMask, ctl;
    logic emp;
    // expected length from the requirements
    if (m) expCycles = N;
    else begin
      zeros = 0; expCycles = 0;
      while (zeros < N) begin
        if (!(expCycles < 16 && pat[expCycles])) zeros++;
        expCycles++;
      end
    end
    @(negedge clk);
    hostWrEn = 1; hostAddr = 0; hostWrData = {28'd0, m, 3'b001}; srcEmpty = 1;
    @(negedge clk);
    hostWrEn = 0;
    readReg(8'd4, rd);
    chk("R2 mask cleared on start", rd, 0);
    taken = 0; rdCount = 0; expMask = 0; c = 0;
    forever begin
      emp = (c < 16) ? pat[c] : 1'b0;
      srcEmpty = emp;
      srcData = base + 32'(taken);
      readReg(8'd0, ctl);
      if (c == 0) chk("R2 busy set, done clear", ctl & 32'h6, 32'h2);
      if (!ctl[1] || c > 40) break;
      if (srcRdEn) begin
        if (emp) chk("R3 read enable while empty", 1, 0);
        rdCount++;
        if (m) begin expData[c] = base + 32'(taken); expMask[c] = 1'b1; end
        else   begin expData[taken] = base + 32'(taken); expMask[taken] = 1'b1; end
        taken++;
      end else if (!emp) chk("R3 read enable low with data present", 0, 1);
      if (inject && c == 1) begin
        hostWrEn = 1; hostWrData = {28'd0, ~m, 3'b001};
      end
      @(negedge clk);
      hostWrEn = 0;
      c++;
    end
    if (m) chk("R6 fixed-length burst cycles", 32'(c), 32'(expCycles));
    else   chk("R4 waiting burst cycles", 32'(c), 32'(expCycles));
    chk("R3 read enable count", 32'(rdCount), m ? 32'(expMask == 0 ? 0 : $countones(expMask)) : 32'(N));
    chk("R5 read enable low after finish", {31'd0, srcRdEn}, 0);
    readReg(8'd0, ctl);
    chk("R5 done set, busy clear", ctl & 32'h6, 32'h4);
    if (inject) chk("R8 mode kept despite start while busy", {31'd0, ctl[3]}, {31'd0, m});
    readReg(8'd4, rd);
    chk("R6 valid mask", rd, m ? expMask : {{(32-N){1'b0}}, {N{1'b1}}});
    for (int i = 0; i < N; i++) begin
      readReg(8'(8 + 4 * i), rd);
      chk("R7 slot contents", rd, expData[i]);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) expData[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 read enable after reset", {31'd0, srcRdEn}, 0);
    readReg(8'd0, rd); chk("R1 control after reset", rd, 0);
    readReg(8'd4, rd); chk("R1 mask after reset", rd, 0);
    readReg(8'd8, rd); chk("R1 slot 0 after reset", rd, 0);
    // R9 idle: no start when bit 0 clear
    @(negedge clk); hostWrEn = 1; hostAddr = 0; hostWrData = 32'h8;
    @(negedge clk); hostWrEn = 0;
    readReg(8'd0, rd); chk("R9 write without start bit stays idle", rd, 0);
    // table of bursts
    for (int e = 0; e < ENTRIES; e++)
      runBurst(VEC[e][17], VEC[e][16], VEC[e][15:0], 32'h100 * 32'(e + 1));
    // R11 done sticky
    repeat (5) @(negedge clk);
    readReg(8'd0, rd); chk("R11 done still set while idle", {31'd0, rd[2]}, 1);
    // R10 unmapped offsets
    readReg(8'd2, rd);  chk("R10 misaligned read", rd, 0);
    readReg(8'd13, rd); chk("R10 misaligned slot read", rd, 0);
    readReg(8'(8 + 4 * N), rd); chk("R10 past last slot", rd, 0);
    readReg(8'd200, rd); chk("R10 far offset", rd, 0);
    // R9 slot offsets after a known burst
    runBurst(1'b0, 1'b0, 16'h0000, 32'hA000);
    readReg(8'(8 + 4 * (N - 1)), rd); chk("R9 last slot offset", rd, 32'hA000 + 32'(N - 1));
    // R1 reset mid-burst
    @(negedge clk); hostWrEn = 1; hostAddr = 0; hostWrData = 32'h1; srcEmpty = 0;
    @(negedge clk); hostWrEn = 0; rst = 1;
    @(negedge clk); rst = 0;
    readReg(8'd0, rd); chk("R1 control after mid-burst reset", rd, 0);
    chk("R1 read enable after mid-burst reset", {31'd0, srcRdEn}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule